// File: doc/BRIEF.md
# Gated Dual Timer/Counter

This block holds two independent 16-bit up-counters. Each counter is stored as a low byte and a high byte, and all of it sits behind a byte-wide register bus with an 8-bit address, a write strobe, write data and combinational read data. A shared control register holds a run bit and an overflow flag for each timer. A mode register gives each timer a gate enable, a count-source select and a two-bit operating mode.

Each timer advances on one of two sources:
- the single-cycle machine tick `tick_i`, or
- a falling edge on its own external count pin, taken after a two-stage synchroniser.

Counting is allowed only while the timer's run bit is set. When the timer's gate bit is set, its gate pin must also be high.

An overflow sets the timer's flag, and the flag drives the interrupt request output. The flag is cleared by a software write or by the interrupt acknowledge input for that timer.

Top module: `gtmr_pair`

## Requirements
- R1: Six registers sit at fixed byte addresses:

  | Address | Register |
  |---|---|
  | 88h | control |
  | 89h | mode |
  | 8Ah | timer 0 low byte |
  | 8Ch | timer 0 high byte |
  | 8Bh | timer 1 low byte |
  | 8Dh | timer 1 high byte |

  All six reset to 00h and read back what was last written. Any other address reads 00h.
- R2: Control bits are: bit 7 timer 1 flag, bit 6 timer 1 run, bit 5 timer 0 flag, bit 4 timer 0 run. Bits 3..0 are plain read/write storage. `ovf_irq_o[1:0]` equals {bit 7, bit 5}.
- R3: The mode register gives timer 1 the upper nibble and timer 0 the lower nibble. Within each nibble, from MSB to LSB, the fields are gate, source select and mode[1:0].
- R4: A timer whose run bit is 0 holds its count.
- R5: With the gate bit at 1, the timer counts only while its `gate_pin_i` bit is high. With the gate bit at 0, the pin has no effect.
- R6: With source select 0, the timer adds one per cycle in which `tick_i` is high. With source select 1, it adds one per 1-to-0 transition of `cnt_pin_i`, seen after two synchroniser flops, and ignores `tick_i`.
- R7: Mode 01 is a 16-bit counter. A step from FFFFh gives 0000h and sets the flag.
- R8: Mode 00 is a 13-bit counter: the high byte plus the low 5 bits of the low byte. A carry out of low bit 4 increments the high byte. A step from high byte FFh with low field 1Fh sets the flag.
- R9: Mode 10 counts the low byte only. A step from FFh reloads the low byte from the high byte and sets the flag.
- R10: Mode 11 stops timer 1. For timer 0, mode 11 splits the counter into two parts:
  - the low byte is an 8-bit counter under timer 0's own controls;
  - the high byte counts `tick_i` while the timer 1 run bit is set, and its FFh-to-00h step sets the timer 1 flag.
- R11: A flag is cleared by a control write with that bit at 0, or by a one-cycle pulse on that timer's `irq_ack_i` bit.
- R12: A hardware overflow in the same cycle as a software clear or an acknowledge leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sfr_addr_i | input | 8 | Register byte address |
| sfr_we_i | input | 1 | Write strobe |
| sfr_wdata_i | input | 8 | Write data |
| sfr_rdata_o | output | 8 | Read data for `sfr_addr_i` |
| tick_i | input | 1 | Internal count enable pulse |
| cnt_pin_i | input | 2 | External count pins, one per timer |
| gate_pin_i | input | 2 | External gate pins, one per timer |
| irq_ack_i | input | 2 | Interrupt acknowledge, one per timer |
| ovf_irq_o | output | 2 | Overflow interrupt requests (flags) |

## Verification
The bench drives 16-bit rollover from random start values near FFFFh. A missing or early carry would show up as a wrong count and a wrong flag there.

It toggles the gate pin randomly under a running timer. A gate sampled late, or ignored, would miscount that run.

It lines up an overflow with a same-cycle software clear and with an acknowledge. A design with the wrong priority would drop the flag.

The auto-reload step, the 13-bit carry out of bit 4, and the split mode (whose high byte sets the other timer's flag) are each probed directly. A wrong reload source, or the flag landing on the wrong timer, shows up as a plain value mismatch.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h88;
  localparam logic [7:0] ADDR_MODE = 8'h89;
  localparam logic [7:0] ADDR_LO0  = 8'h8A;
  localparam logic [7:0] ADDR_LO1  = 8'h8B;
  localparam logic [7:0] ADDR_HI0  = 8'h8C;
  localparam logic [7:0] ADDR_HI1  = 8'h8D;

  typedef enum logic [1:0] {
    MODE_13     = 2'b00,
    MODE_16     = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_STOP   = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext_src;
    tmr_mode_e mode;
  } tmr_cfg_t;
endpackage

// File: rtl/gtmr_pin_sync.sv
module gtmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic en_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  // edge only counts while the owning timer is enabled
  assign fall_o = en_i & last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/gtmr_core.sv
module gtmr_core
  import gtmr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PRE_W = 5,
  parameter bit SPLIT = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  tmr_cfg_t      cfg_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          ext_fall_i,
  input  logic          hi_run_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o,
  output logic          ovf_o,
  output logic          hi_ovf_o
);
  logic [DW-1:0] lo_q, hi_q, lo_n, hi_n;
  logic          inc;

  assign inc = run_i & (cfg_i.ext_src ? ext_fall_i : tick_i);

  always_comb begin
    lo_n     = lo_q;
    hi_n     = hi_q;
    ovf_o    = 1'b0;
    hi_ovf_o = 1'b0;
    unique case (cfg_i.mode)
      MODE_13: if (inc) begin
        if (&lo_q[PRE_W-1:0]) begin
          lo_n[PRE_W-1:0] = '0;
          hi_n            = hi_q + 1'b1;
          ovf_o           = &hi_q;
        end else begin
          lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
        end
      end
      MODE_16: if (inc) begin
        {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
        ovf_o        = &{hi_q, lo_q};
      end
      MODE_RELOAD: if (inc) begin
        if (&lo_q) begin
          lo_n  = hi_q;
          ovf_o = 1'b1;
        end else begin
          lo_n = lo_q + 1'b1;
        end
      end
      MODE_STOP: if (SPLIT) begin
        if (inc) begin
          lo_n  = lo_q + 1'b1;
          ovf_o = &lo_q;
        end
        if (hi_run_i && tick_i) begin
          hi_n     = hi_q + 1'b1;
          hi_ovf_o = &hi_q;
        end
      end
      default: ;
    endcase
  end

  // software write takes the register over the count step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= wr_lo_i ? wdata_i : lo_n;
      hi_q <= wr_hi_i ? wdata_i : hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/gtmr_pair.sv
module gtmr_pair
  import gtmr_pkg::*;
#(
  parameter int DW       = 8,
  parameter int N_TMR    = 2,
  parameter int SYNC_STG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       sfr_addr_i,
  input  logic             sfr_we_i,
  input  logic [DW-1:0]    sfr_wdata_i,
  output logic [DW-1:0]    sfr_rdata_o,
  input  logic             tick_i,
  input  logic [N_TMR-1:0] cnt_pin_i,
  input  logic [N_TMR-1:0] gate_pin_i,
  input  logic [N_TMR-1:0] irq_ack_i,
  output logic [N_TMR-1:0] ovf_irq_o
);
  localparam int CFG_W = $bits(tmr_cfg_t);

  logic [DW-1:0]    ctrl_q, mode_q, ctrl_n;
  logic [DW-1:0]    lo_w [N_TMR];
  logic [DW-1:0]    hi_w [N_TMR];
  tmr_cfg_t         cfg_w [N_TMR];
  logic [N_TMR-1:0] tr_w, run_w, fall_w, ovf_w, hi_ovf_w, set_w;
  logic [N_TMR-1:0] wr_lo_w, wr_hi_w;
  logic             wr_ctrl_w, wr_mode_w, split_w;

  assign wr_ctrl_w = sfr_we_i && (sfr_addr_i == ADDR_CTRL);
  assign wr_mode_w = sfr_we_i && (sfr_addr_i == ADDR_MODE);
  assign split_w   = (cfg_w[0].mode == MODE_STOP);

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    assign cfg_w[g]   = tmr_cfg_t'(mode_q[CFG_W*g +: CFG_W]);
    assign tr_w[g]    = ctrl_q[4 + 2*g];
    assign run_w[g]   = tr_w[g] & (~cfg_w[g].gate | gate_pin_i[g]);
    assign wr_lo_w[g] = sfr_we_i && (sfr_addr_i == ADDR_LO0 + 8'(g));
    assign wr_hi_w[g] = sfr_we_i && (sfr_addr_i == ADDR_HI0 + 8'(g));
    assign ovf_irq_o[g] = ctrl_q[5 + 2*g];

    gtmr_pin_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (cnt_pin_i[g]),
      .en_i  (run_w[g]),
      .fall_o(fall_w[g])
    );

    gtmr_core #(.DW(DW), .SPLIT(g == 0)) u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_i     (cfg_w[g]),
      .run_i     (run_w[g]),
      .tick_i    (tick_i),
      .ext_fall_i(fall_w[g]),
      .hi_run_i  (tr_w[N_TMR-1]),
      .wr_lo_i   (wr_lo_w[g]),
      .wr_hi_i   (wr_hi_w[g]),
      .wdata_i   (sfr_wdata_i),
      .lo_o      (lo_w[g]),
      .hi_o      (hi_w[g]),
      .ovf_o     (ovf_w[g]),
      .hi_ovf_o  (hi_ovf_w[g])
    );
  end

  // split timer 0 high byte owns timer 1's flag
  assign set_w[0] = ovf_w[0];
  assign set_w[1] = split_w ? hi_ovf_w[0] : (ovf_w[1] | hi_ovf_w[1]);

  always_comb begin
    ctrl_n = wr_ctrl_w ? sfr_wdata_i : ctrl_q;
    for (int i = 0; i < N_TMR; i++) begin
      if (irq_ack_i[i]) ctrl_n[5 + 2*i] = 1'b0;
      if (set_w[i])     ctrl_n[5 + 2*i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      if (wr_mode_w) mode_q <= sfr_wdata_i;
    end
  end

  always_comb begin
    unique case (sfr_addr_i)
      ADDR_CTRL: sfr_rdata_o = ctrl_q;
      ADDR_MODE: sfr_rdata_o = mode_q;
      ADDR_LO0:  sfr_rdata_o = lo_w[0];
      ADDR_LO1:  sfr_rdata_o = lo_w[1];
      ADDR_HI0:  sfr_rdata_o = hi_w[0];
      ADDR_HI1:  sfr_rdata_o = hi_w[1];
      default:   sfr_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gtmr_pair_chk.sv
module gtmr_pair_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] ctrl_q,
  input logic [7:0] mode_q,
  input logic [7:0] tl0_i,
  input logic [7:0] tl1_i,
  input logic [1:0] wr_lo_w,
  input logic [1:0] set_w,
  input logic [1:0] gate_pin_i,
  input logic [1:0] irq_ack_i
);
  p_stop_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[4] && !wr_lo_w[0]) |=> $stable(tl0_i));

  p_gate_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[3] && !gate_pin_i[0] && !wr_lo_w[0]) |=> $stable(tl0_i));

  p_t1_stopped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[5:4] == 2'b11 && !wr_lo_w[1]) |=> $stable(tl1_i));

  p_ack_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i[0] && !set_w[0]) |=> !ctrl_q[5]);

  p_set_wins0_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_w[0] |=> ctrl_q[5]);

  p_set_wins1_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_w[1] |=> ctrl_q[7]);
endmodule

bind gtmr_pair gtmr_pair_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_q    (ctrl_q),
  .mode_q    (mode_q),
  .tl0_i     (lo_w[0]),
  .tl1_i     (lo_w[1]),
  .wr_lo_w   (wr_lo_w),
  .set_w     (set_w),
  .gate_pin_i(gate_pin_i),
  .irq_ack_i (irq_ack_i)
);

// File: tb/gtmr_pair_tb.sv
module gtmr_pair_tb;
  localparam logic [7:0] A_CTRL = 8'h88, A_MODE = 8'h89;
  localparam logic [7:0] A_LO0 = 8'h8A, A_LO1 = 8'h8B, A_HI0 = 8'h8C, A_HI1 = 8'h8D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic       we = 1'b0, tick = 1'b0;
  logic [1:0] cnt_pin = 2'b11, gate_pin = 2'b00, ack = 2'b00, irq;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  gtmr_pair u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sfr_addr_i(addr), .sfr_we_i(we),
    .sfr_wdata_i(wdata), .sfr_rdata_o(rdata), .tick_i(tick),
    .cnt_pin_i(cnt_pin), .gate_pin_i(gate_pin), .irq_ack_i(ack), .ovf_irq_o(irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic logic [16:0] exp16(input logic [15:0] s, input int n);
    return {1'b0, s} + 17'(n);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v, v2;
    logic [7:0]  regs [6];
    logic [16:0] e;
    int          cnt;
    void'($urandom(32'h1357_2468));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    regs = '{A_CTRL, A_MODE, A_LO0, A_LO1, A_HI0, A_HI1};
    foreach (regs[i]) begin rd(regs[i], v); chk("R1 reset", v, 0); end
    rd(8'h90, v); chk("R1 unmapped", v, 0);

    // R1/R2/R3 random readback, tick idle so nothing counts
    for (int it = 0; it < 6; it++) begin
      logic [7:0] d;
      d = 8'($urandom);
      wr(A_MODE, 8'($urandom)); wr(A_CTRL, d);
      rd(A_CTRL, v); chk("R2 ctrl readback", v, d);
      chk("R2 irq mirrors flags", irq, {d[7], d[5]});
      d = 8'($urandom); wr(A_LO1, d); rd(A_LO1, v); chk("R1 lo1 readback", v, d);
      d = 8'($urandom); wr(A_HI1, d); rd(A_HI1, v); chk("R1 hi1 readback", v, d);
    end
    wr(A_MODE, 8'h5A); rd(A_MODE, v); chk("R3 mode readback", v, 8'h5A);
    wr(A_CTRL, 8'h00);

    // R4 halted timer holds
    wr(A_MODE, 8'h01); wr(A_LO0, 8'h33); wr(A_HI0, 8'h00);
    ticks(7); rd(A_LO0, v); chk("R4 halted", v, 8'h33);

    // R7 random 16-bit runs, biased to rollover
    for (int it = 0; it < 24; it++) begin
      int idx, n;
      logic [15:0] s;
      idx = $urandom_range(1, 0);
      n   = $urandom_range(60, 1);
      s   = (it % 2 == 0) ? 16'hFFFF - 16'($urandom_range(40, 0)) : 16'($urandom);
      wr(A_CTRL, 8'h00);
      wr(A_MODE, idx == 1 ? 8'h10 : 8'h01);
      wr(A_LO0 + 8'(idx), s[7:0]); wr(A_HI0 + 8'(idx), s[15:8]);
      wr(A_CTRL, 8'(1 << (4 + 2*idx)));
      ticks(n);
      e = exp16(s, n);
      rd(A_LO0 + 8'(idx), v); rd(A_HI0 + 8'(idx), v2);
      chk("R7 16-bit count", {v2, v}, e[15:0]);
      chk("R7 16-bit flag", irq[idx], e[16]);
    end
    // directed FFFF -> 0000
    wr(A_CTRL, 8'h00); wr(A_MODE, 8'h01); wr(A_LO0, 8'hFF); wr(A_HI0, 8'hFF);
    wr(A_CTRL, 8'h10); ticks(1);
    rd(A_LO0, v); rd(A_HI0, v2);
    chk("R7 wrap value", {v2, v}, 16'h0000); chk("R7 wrap flag", irq[0], 1);

    // R11 acknowledge clears, software clear of timer 1 flag
    ack = 2'b01; @(negedge clk); ack = 2'b00;
    chk("R11 ack clears", irq[0], 0);
    wr(A_CTRL, 8'h80); chk("R11 sw set", irq[1], 1);
    wr(A_CTRL, 8'h00); chk("R11 sw clear", irq[1], 0);

    // R12 overflow beats same-cycle software clear
    wr(A_LO0, 8'hFF); wr(A_HI0, 8'hFF); wr(A_CTRL, 8'h10);
    tick = 1'b1; wr(A_CTRL, 8'h10); tick = 1'b0;
    chk("R12 set beats sw clear", irq[0], 1);
    wr(A_LO0, 8'hFF); wr(A_HI0, 8'hFF);
    tick = 1'b1; ack = 2'b01; @(negedge clk); tick = 1'b0; ack = 2'b00;
    chk("R12 set beats ack", irq[0], 1);
    ack = 2'b01; @(negedge clk); ack = 2'b00;

    // R5 gating with random pin pattern
    wr(A_CTRL, 8'h00); wr(A_MODE, 8'h09); wr(A_LO0, 8'h00); wr(A_HI0, 8'h00);
    wr(A_CTRL, 8'h10);
    cnt = 0;
    for (int c = 0; c < 20; c++) begin
      logic b;
      b = 1'($urandom);
      gate_pin[0] = b; tick = 1'b1; cnt += int'(b);
      @(negedge clk);
    end
    tick = 1'b0; gate_pin[0] = 1'b0;
    rd(A_LO0, v); chk("R5 gated count", v, cnt);
    wr(A_MODE, 8'h01); wr(A_LO0, 8'h00); gate_pin[0] = 1'b0;
    ticks(6); rd(A_LO0, v); chk("R5 gate off ignores pin", v, 6);

    // R6 external falling edges
    wr(A_CTRL, 8'h00); wr(A_MODE, 8'h05); wr(A_LO0, 8'h00); wr(A_CTRL, 8'h10);
    ticks(5); rd(A_LO0, v); chk("R6 tick ignored", v, 0);
    for (int k = 0; k < 3; k++) begin
      cnt_pin[0] = 1'b0; repeat (4) @(negedge clk);
      cnt_pin[0] = 1'b1; repeat (4) @(negedge clk);
    end
    rd(A_LO0, v); chk("R6 edge count", v, 3);
    wr(A_CTRL, 8'h00);
    cnt_pin[0] = 1'b0; repeat (4) @(negedge clk);
    cnt_pin[0] = 1'b1; repeat (4) @(negedge clk);
    wr(A_CTRL, 8'h10); repeat (4) @(negedge clk);
    rd(A_LO0, v); chk("R6 edge while halted", v, 3);

    // R8 13-bit carry and wrap
    wr(A_CTRL, 8'h00); wr(A_MODE, 8'h00); wr(A_LO0, 8'h1E); wr(A_HI0, 8'h00);
    wr(A_CTRL, 8'h10); ticks(2);
    rd(A_LO0, v); rd(A_HI0, v2);
    chk("R8 low field wrap", v, 8'h00); chk("R8 carry to high", v2, 8'h01);
    wr(A_LO0, 8'h1F); wr(A_HI0, 8'hFF); ticks(1);
    rd(A_HI0, v2); chk("R8 13-bit wrap", v2, 0); chk("R8 13-bit flag", irq[0], 1);

    // R9 auto-reload
    wr(A_CTRL, 8'h00); wr(A_MODE, 8'h02); wr(A_HI0, 8'hF0); wr(A_LO0, 8'hFE);
    wr(A_CTRL, 8'h10); ticks(3);
    rd(A_LO0, v); rd(A_HI0, v2);
    chk("R9 reload value", v, 8'hF1); chk("R9 high kept", v2, 8'hF0);
    chk("R9 reload flag", irq[0], 1);

    // R10 timer 1 stopped, timer 0 split
    wr(A_CTRL, 8'h00); wr(A_MODE, 8'h30); wr(A_LO1, 8'h10); wr(A_CTRL, 8'h40);
    ticks(5); rd(A_LO1, v); chk("R10 t1 stopped", v, 8'h10);
    wr(A_CTRL, 8'h00); wr(A_MODE, 8'h03); wr(A_HI0, 8'hFE); wr(A_LO0, 8'h22);
    wr(A_CTRL, 8'h40); ticks(3);
    rd(A_HI0, v); rd(A_LO0, v2);
    chk("R10 split high count", v, 8'h01); chk("R10 split low held", v2, 8'h22);
    chk("R10 split sets t1 flag", irq[1], 1); chk("R10 t0 flag clear", irq[0], 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule